// File: doc/BRIEF.md
# Dual-Code Bit Line Encoder

This block converts a serial bit stream into a DC-balanced line signal for a short-range vehicular baseband transmitter. A select input chooses between two bit codes. In the bi-phase space code (FM0), the level flips at every bit boundary and a zero adds a second flip in the middle of the bit. In the Manchester code, a one is sent as high then low and a zero as low then high. The same small datapath forms the chips for both codes. The code select changes only how that datapath's shared gates combine the held bit with the previous line level.

The encoder runs on a clock at twice the bit rate, so every bit becomes two half-bit chips on `line_out`. A registered `bit_strobe` marks the cycle at whose closing edge the encoder takes the next data bit and the next code select. The source drives its bit while the strobe is high. A clear input `clr` is kept separate from the code select. It resets the half-bit phase, forces the line low and sets the remembered previous level to low. A system controller can therefore pick a code and restart the encoder as two independent actions.

Top module: `dual_line_encoder`

## Requirements
- R1: While `clr` is high at a clock edge, the following cycle shows `line_out` = 0 and `bit_strobe` = 1, and the previous-level state is low.
- R2: After `clr` falls, `bit_strobe` is 1 in the first cycle and then alternates every cycle, so one bit period is two clock cycles.
- R3: `data_in` and `code_sel` are sampled at the edge that ends a cycle with `bit_strobe` = 1. The next cycle shows the first chip of that bit on `line_out`, and the cycle after it shows the second chip.
- R4: With `code_sel` = 1 (Manchester), a data 1 is sent as chips 1 then 0, and a data 0 as chips 0 then 1.
- R5: With `code_sel` = 0 (FM0), the first chip of each bit is the inverse of the line level in the cycle just before it.
- R6: In FM0, a data 1 keeps its second chip equal to its first, and a data 0 makes the second chip the inverse of the first.
- R7: Changes on `data_in` or `code_sel` during a cycle with `bit_strobe` = 0 have no effect on the bit being sent.
- R8: Each bit is coded wholly in the code sampled with it. When the code changes between bits, FM0 takes the last chip sent in Manchester as its previous level.
- R9: A `clr` raised in the middle of a bit abandons that bit. After release, the first FM0 bit starts from a previous level of low, so its first chip is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| clr | input | 1 | Synchronous active-high clear of phase, line level and held bit |
| code_sel | input | 1 | Code select: 0 FM0, 1 Manchester; sampled with each bit |
| data_in | input | 1 | Serial data bit, sampled at the end of a strobe-high cycle |
| bit_strobe | output | 1 | High in the cycle whose closing edge takes the next bit |
| line_out | output | 1 | Registered coded chip stream |

## Verification
The assertions assume that `clr` is held high from time zero for at least one edge. They also assume that the cycle after a clear is the start of a fresh bit period, so their checks of transitions against the previous line level skip the cycle that directly follows a clear. The bench drives inputs only on falling clock edges. It normally changes `data_in` and `code_sel` while `bit_strobe` is high. It also toggles them on purpose in strobe-low cycles, which exercises the claim that the held bit and held code change only at a bit boundary. Clears are applied both at bit boundaries and part-way through a bit.

// File: rtl/line_code_pkg.sv
package line_code_pkg;

  typedef enum logic {
    CODE_FM0   = 1'b0,
    CODE_MANCH = 1'b1
  } code_e;

  typedef struct packed {
    code_e code;
    logic  data;
  } bit_ctx_t;

  localparam bit_ctx_t CTX_IDLE = '{code: CODE_FM0, data: 1'b0};

endpackage

// File: rtl/half_phase_gen.sv
module half_phase_gen (
  input  logic clk,
  input  logic clr,
  output logic first_next
);

  logic first_q;

  always_ff @(posedge clk) begin
    if (clr) first_q <= 1'b1;
    else     first_q <= ~first_q;
  end

  assign first_next = first_q;

  // R2
  strobe_alternate_chk: assert property (@(posedge clk) disable iff (clr)
    !$past(clr) |-> (first_q != $past(first_q)));

endmodule

// File: rtl/bit_sampler.sv
module bit_sampler
  import line_code_pkg::*;
(
  input  logic     clk,
  input  logic     clr,
  input  logic     take,
  input  logic     data_in,
  input  logic     code_in,
  output bit_ctx_t ctx
);

  bit_ctx_t ctx_q;

  always_ff @(posedge clk) begin
    if (clr)       ctx_q <= CTX_IDLE;
    else if (take) ctx_q <= '{code: code_e'(code_in), data: data_in};
  end

  assign ctx = ctx_q;

  // R7
  held_bit_stable_chk: assert property (@(posedge clk) disable iff (clr)
    (!$past(clr) && !$past(take)) |-> $stable(ctx_q));

endmodule

// File: rtl/chip_former.sv
module chip_former
  import line_code_pkg::*;
(
  input  bit_ctx_t ctx_now,
  input  logic     data_new,
  input  logic     code_new,
  input  logic     first_half,
  input  logic     line_now,
  output logic     chip_next
);

  logic data_use;
  logic code_use;
  logic flip;
  logic first_chip;

  always_comb begin
    data_use   = first_half ? data_new : ctx_now.data;
    code_use   = first_half ? code_new : ctx_now.code;
    // Shared gates: the first chip uses the data for one code and the
    // inverted line for the other; the second chip flips unless FM0 holds a one.
    first_chip = code_use ? data_use : ~line_now;
    flip       = code_use | ~data_use;
    chip_next  = first_half ? first_chip : (line_now ^ flip);
  end

endmodule

// File: rtl/dual_line_encoder.sv
module dual_line_encoder
  import line_code_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic code_sel,
  input  logic data_in,
  output logic bit_strobe,
  output logic line_out
);

  logic     first_next;
  bit_ctx_t ctx;
  logic     chip_next;
  logic     line_q;
  logic     clr_seen_q;

  half_phase_gen u_phase (
    .clk        (clk),
    .clr        (clr),
    .first_next (first_next)
  );

  bit_sampler u_sampler (
    .clk     (clk),
    .clr     (clr),
    .take    (first_next),
    .data_in (data_in),
    .code_in (code_sel),
    .ctx     (ctx)
  );

  chip_former u_former (
    .ctx_now    (ctx),
    .data_new   (data_in),
    .code_new   (code_sel),
    .first_half (first_next),
    .line_now   (line_q),
    .chip_next  (chip_next)
  );

  always_ff @(posedge clk) begin
    if (clr) line_q <= 1'b0;
    else     line_q <= chip_next;
  end

  assign bit_strobe = first_next;
  assign line_out   = line_q;

  always_ff @(posedge clk) begin
    clr_seen_q <= clr;
    if (clr_seen_q) begin
      // R1
      clear_low_chk: assert (!line_q && first_next)
        else $error("line not low or phase not reset after clear");
    end
  end

  // R5
  fm0_boundary_flip_chk: assert property (@(posedge clk) disable iff (clr)
    (!first_next && ctx.code == CODE_FM0) |-> (line_q != $past(line_q)));

  // R6
  fm0_one_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (first_next && !$past(clr) && ctx.code == CODE_FM0 && ctx.data)
      |-> (line_q == $past(line_q)));

  // R4
  manch_mid_flip_chk: assert property (@(posedge clk) disable iff (clr)
    (first_next && !$past(clr) && ctx.code == CODE_MANCH)
      |-> (line_q != $past(line_q)));

  // R3
  manch_first_chip_chk: assert property (@(posedge clk) disable iff (clr)
    (!first_next && ctx.code == CODE_MANCH) |-> (line_q == ctx.data));

endmodule

// File: tb/dual_line_encoder_bench.sv
`timescale 1ns/1ps
module dual_line_encoder_bench;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic code_sel = 1'b0;
  logic data_in = 1'b0;
  logic bit_strobe;
  logic line_out;

  int total = 0;
  int bad = 0;
  logic exp_level = 1'b0;

  always #10 clk = ~clk;

  dual_line_encoder u_dual_line_encoder (
    .clk        (clk),
    .clr        (clr),
    .code_sel   (code_sel),
    .data_in    (data_in),
    .bit_strobe (bit_strobe),
    .line_out   (line_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Ends at a falling edge with bit_strobe high and the expected level low.
  task automatic do_clear(input int cycles);
    @(negedge clk);
    clr = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check("R1 line low in clear", line_out, 1'b0);
      check("R1 strobe in clear", bit_strobe, 1'b1);
    end
    clr = 1'b0;
    exp_level = 1'b0;
  endtask

  // Called at a falling edge with bit_strobe high; returns at the next such edge.
  task automatic send_bit(input logic d, input logic m, input logic glitch);
    logic c1;
    logic c2;
    data_in  = d;
    code_sel = m;
    if (m) begin
      c1 = d;
      c2 = ~d;
    end else begin
      c1 = ~exp_level;
      c2 = d ? c1 : ~c1;
    end
    @(negedge clk);
    check("R2 strobe low in first half", bit_strobe, 1'b0);
    check(m ? "R4 manchester first chip" : "R5 fm0 first chip", line_out, c1);
    if (glitch) begin
      data_in  = ~d;
      code_sel = ~m;
    end
    @(negedge clk);
    check("R2 strobe high in second half", bit_strobe, 1'b1);
    check(glitch ? "R7 second chip after glitch" :
          (m ? "R4 manchester second chip" : "R6 fm0 second chip"), line_out, c2);
    exp_level = c2;
  endtask

  task automatic t_reset();
    data_in  = 1'b1;
    code_sel = 1'b1;
    do_clear(3);
    send_bit(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_manchester();
    logic [5:0] pat = 6'b100110;
    do_clear(1);
    for (int i = 5; i >= 0; i--) send_bit(pat[i], 1'b1, 1'b0);
  endtask

  task automatic t_fm0();
    logic [7:0] pat = 8'b00110100;
    do_clear(1);
    for (int i = 7; i >= 0; i--) send_bit(pat[i], 1'b0, 1'b0);
  endtask

  task automatic t_ignore_midbit();
    do_clear(1);
    send_bit(1'b1, 1'b0, 1'b1);
    send_bit(1'b0, 1'b0, 1'b1);
    send_bit(1'b1, 1'b1, 1'b1);
    send_bit(1'b0, 1'b1, 1'b1);
    check("R7 line level held after glitches", line_out, exp_level);
  endtask

  task automatic t_mode_switch();
    do_clear(1);
    // R8: frame-wise switching, then bit-wise alternation
    for (int i = 0; i < 4; i++) send_bit(i[0], 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) send_bit(~i[1], 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) send_bit(i[1], 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send_bit(i[2] ^ i[0], i[0], 1'b0);
  endtask

  task automatic t_clear_midbit();
    do_clear(1);
    send_bit(1'b1, 1'b1, 1'b0);
    data_in  = 1'b1;
    code_sel = 1'b1;
    @(negedge clk);
    check("R9 first chip before abort", line_out, 1'b1);
    clr = 1'b1;
    @(negedge clk);
    check("R9 line low after mid-bit clear", line_out, 1'b0);
    check("R9 strobe after mid-bit clear", bit_strobe, 1'b1);
    clr = 1'b0;
    exp_level = 1'b0;
    send_bit(1'b1, 1'b0, 1'b0);
    check("R9 fm0 restarts from low", line_out, 1'b1);
  endtask

  initial begin
    #4_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_manchester();
    t_fm0();
    t_ignore_midbit();
    t_mode_switch();
    t_clear_midbit();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule